// File: doc/BRIEF.md
# Sixteen-Bit Integer ALU with Boolean Compare

This block is the purely combinational arithmetic and logic unit of a small register machine. It receives two 16-bit operand words and a 5-bit function code, and drives a single 16-bit result word in the same cycle. It has no clock, no storage and no flag outputs. Whatever selects between a register operand and a constant operand sits upstream of this block, and it sees both cases as a plain word on its second operand.

The supported operations are these:

- add and subtract, both wrapping modulo 2^16;
- bitwise AND, OR and XOR;
- left shift, logical right shift and arithmetic right shift, where the distance comes only from the low four bits of the second operand;
- four comparisons: equality, signed less-than, signed less-or-equal and unsigned less-than. Each comparison writes a full word that is exactly 0 or 1.

Any function code outside the defined set produces a zero result.

Top module: `alu16`

## Requirements
- R1: Code 5'h00 (add) yields (A + B) mod 2^16.
- R2: Code 5'h01 (subtract) yields (A - B) mod 2^16.
- R3: Codes 5'h08, 5'h09 and 5'h0A yield the bitwise AND, OR and XOR of A and B respectively.
- R4: Code 5'h10 (left shift) shifts A left by B[3:0] places and fills with zeros. Bits B[15:4] have no effect on any shift.
- R5: Code 5'h11 (logical right shift) shifts A right by B[3:0] places and fills the vacated high bits with zeros.
- R6: Code 5'h13 (arithmetic right shift) shifts A right by B[3:0] places and fills the vacated high bits with copies of A[15].
- R7: For any of the three shift codes, when B[3:0] is zero the result equals A unchanged.
- R8: Code 5'h18 yields 1 when A equals B, and 0 otherwise.
- R9: Code 5'h19 yields 1 when A < B as two's-complement signed values, and 0 otherwise.
- R10: Code 5'h1A yields 1 when A <= B as two's-complement signed values, and 0 otherwise.
- R11: Code 5'h1B yields 1 when A < B as unsigned values, and 0 otherwise.
- R12: Every function code not listed in R1 to R11 yields a result of 16'h0000.
- R13: For every compare code, result bits [15:1] are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand word (A) |
| opnd_b | input | 16 | Second operand word (B); the shift distance is taken from its low four bits |
| func_sel | input | 5 | Function code |
| result | output | 16 | Result word |

## Verification
The embedded immediate checks assume that both operands and the function code are fully driven, known values that are stable while the result is evaluated. They compare the results of the subtraction-based comparisons and of the staged shifter against direct operator forms, and this comparison only has meaning for settled inputs. The bench changes its inputs only on the falling clock edge and reads the result half a period later, so each evaluation sees one settled operand set. Every run starts from all-zero inputs, so no unknown value ever reaches the design.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int FUNC_W = 5;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD  = 5'h00,
    FN_SUB  = 5'h01,
    FN_AND  = 5'h08,
    FN_OR   = 5'h09,
    FN_XOR  = 5'h0A,
    FN_SHL  = 5'h10,
    FN_SHR  = 5'h11,
    FN_SRA  = 5'h13,
    FN_CEQ  = 5'h18,
    FN_CLT  = 5'h19,
    FN_CLE  = 5'h1A,
    FN_CULT = 5'h1B
  } alu_fn_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_op_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o,
  output logic              eq_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sub_full;
  logic [DATA_W-1:0] diff_w;
  logic              carry_out;
  logic              ovf;

  always_comb begin
    sub_full  = {1'b0, a_i} + {1'b0, ~b_i} + (DATA_W+1)'(1);
    diff_w    = sub_full[DATA_W-1:0];
    carry_out = sub_full[DATA_W];
    ovf       = (a_i[MSB] != b_i[MSB]) && (diff_w[MSB] != a_i[MSB]);
  end

  assign sum_o  = a_i + b_i;
  assign diff_o = diff_w;
  assign eq_o   = ~|diff_w;
  assign lt_u_o = ~carry_out;
  assign lt_s_o = diff_w[MSB] ^ ovf;

  // Subtraction-derived comparisons cross-checked against direct operators
  always_comb begin
    p_equal_r8: assert (eq_o == (a_i == b_i));
    p_signed_lt_r9: assert (lt_s_o == ($signed(a_i) < $signed(b_i)));
    p_unsigned_lt_r11: assert (lt_u_o == (a_i < b_i));
  end

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  input  alu16_pkg::bw_op_e     op_i,
  output logic [DATA_W-1:0]     y_o
);

  import alu16_pkg::*;

  always_comb begin
    unique case (op_i)
      BW_AND:  y_o = a_i & b_i;
      BW_OR:   y_o = a_i | b_i;
      BW_XOR:  y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]         a_i,
  input  logic [$clog2(DATA_W)-1:0] dist_i,
  input  logic                      left_i,
  input  logic                      arith_i,
  output logic [DATA_W-1:0]         y_o
);

  localparam int DIST_W = $clog2(DATA_W);
  localparam int MSB    = DATA_W - 1;

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[MSB-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stage [DIST_W+1];
  logic              fill;

  assign fill     = arith_i & ~left_i & a_i[MSB];
  assign stage[0] = left_i ? bit_rev(a_i) : a_i;

  // One conditional right-shift stage per bit of the distance
  for (genvar k = 0; k < DIST_W; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    assign stage[k+1] = dist_i[k] ? {{STEP{fill}}, stage[k][MSB:STEP]} : stage[k];
  end

  assign y_o = left_i ? bit_rev(stage[DIST_W]) : stage[DIST_W];

  always_comb begin
    if (left_i) begin
      p_shift_left_r4: assert (y_o == (a_i << dist_i));
    end else if (!arith_i) begin
      p_shift_logical_r5: assert (y_o == (a_i >> dist_i));
    end else begin
      p_shift_arith_r6: assert (y_o == DATA_W'($signed(a_i) >>> dist_i));
    end
  end

endmodule

// File: rtl/alu16.sv
module alu16 #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]            opnd_a,
  input  logic [DATA_W-1:0]            opnd_b,
  input  logic [alu16_pkg::FUNC_W-1:0] func_sel,
  output logic [DATA_W-1:0]            result
);

  import alu16_pkg::*;

  localparam int DIST_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sum_w, diff_w, bw_w, sh_w;
  logic              eq_w, lt_s_w, lt_u_w;
  bw_op_e            bw_op;
  logic              sh_left, sh_arith;
  logic              is_cmp, is_shift, is_known;

  alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .sum_o  (sum_w),
    .diff_o (diff_w),
    .eq_o   (eq_w),
    .lt_s_o (lt_s_w),
    .lt_u_o (lt_u_w)
  );

  alu16_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .op_i (bw_op),
    .y_o  (bw_w)
  );

  alu16_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i     (opnd_a),
    .dist_i  (opnd_b[DIST_W-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .y_o     (sh_w)
  );

  // Function decode for the sub-units
  always_comb begin
    bw_op    = BW_AND;
    sh_left  = 1'b0;
    sh_arith = 1'b0;
    case (func_sel)
      FN_OR:   bw_op = BW_OR;
      FN_XOR:  bw_op = BW_XOR;
      FN_SHL:  sh_left = 1'b1;
      FN_SRA:  sh_arith = 1'b1;
      default: ;
    endcase
  end

  // Result selection
  always_comb begin
    case (func_sel)
      FN_ADD:                 result = sum_w;
      FN_SUB:                 result = diff_w;
      FN_AND, FN_OR, FN_XOR:  result = bw_w;
      FN_SHL, FN_SHR, FN_SRA: result = sh_w;
      FN_CEQ:                 result = DATA_W'(eq_w);
      FN_CLT:                 result = DATA_W'(lt_s_w);
      FN_CLE:                 result = DATA_W'(lt_s_w | eq_w);
      FN_CULT:                result = DATA_W'(lt_u_w);
      default:                result = '0;
    endcase
  end

  assign is_cmp   = func_sel inside {FN_CEQ, FN_CLT, FN_CLE, FN_CULT};
  assign is_shift = func_sel inside {FN_SHL, FN_SHR, FN_SRA};
  assign is_known = is_cmp || is_shift ||
                    (func_sel inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR});

  always_comb begin
    if (is_cmp) begin
      p_cmp_boolean_r13: assert (result[DATA_W-1:1] == '0);
    end
    if (!is_known) begin
      p_unused_zero_r12: assert (result == '0);
    end
    if (is_shift && (opnd_b[DIST_W-1:0] == '0)) begin
      p_zero_shift_r7: assert (result == opnd_a);
    end
    if (func_sel == FN_CLE) begin
      p_le_signed_r10: assert (result[0] == ($signed(opnd_a) <= $signed(opnd_b)));
    end
  end

endmodule

// File: tb/alu16_bench.sv
module alu16_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] a, b, y;
  logic [4:0]  f;
  int          n_run, n_fail;
  bit          done;

  alu16 u_alu16 (.opnd_a(a), .opnd_b(b), .func_sel(f), .result(y));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] z,
                                        input logic [4:0] fn);
    case (fn)
      5'h00: return x + z;
      5'h01: return x - z;
      5'h08: return x & z;
      5'h09: return x | z;
      5'h0A: return x ^ z;
      5'h10: return x << z[3:0];
      5'h11: return x >> z[3:0];
      5'h13: return 16'($signed(x) >>> z[3:0]);
      5'h18: return {15'd0, x == z};
      5'h19: return {15'd0, $signed(x) < $signed(z)};
      5'h1A: return {15'd0, $signed(x) <= $signed(z)};
      5'h1B: return {15'd0, x < z};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h f=%h got=%h expected=%h", tag, a, b, f, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] x, input logic [15:0] z,
                       input logic [4:0] fn, input logic [15:0] exp);
    @(negedge clk);
    a = x; b = z; f = fn;
    @(posedge clk);
    check(tag, y, exp);
  endtask

  task automatic t_reset;
    apply("R1 reset-state", 16'h0000, 16'h0000, 5'h00, 16'h0000);
  endtask

  task automatic t_add;
    apply("R1 add", 16'h1234, 16'h0F0F, 5'h00, 16'h2143);
    apply("R1 add-wrap", 16'hFFFF, 16'h0002, 5'h00, 16'h0001);
    apply("R1 add-wrap-max", 16'h8000, 16'h8000, 5'h00, 16'h0000);
  endtask

  task automatic t_sub;
    apply("R2 sub", 16'h0100, 16'h0001, 5'h01, 16'h00FF);
    apply("R2 sub-wrap", 16'h0000, 16'h0001, 5'h01, 16'hFFFF);
  endtask

  task automatic t_logic;
    apply("R3 and", 16'hF0F0, 16'hFF00, 5'h08, 16'hF000);
    apply("R3 or",  16'hF0F0, 16'h0F00, 5'h09, 16'hFFF0);
    apply("R3 xor", 16'hAAAA, 16'hFFFF, 5'h0A, 16'h5555);
  endtask

  task automatic t_shl;
    apply("R4 shl", 16'h0001, 16'h0004, 5'h10, 16'h0010);
    apply("R4 shl-max", 16'h0003, 16'h000F, 5'h10, 16'h8000);
    apply("R4 shl-highbits-ignored", 16'h0001, 16'hFFF3, 5'h10, 16'h0008);
  endtask

  task automatic t_shr;
    apply("R5 shr", 16'h8000, 16'h0004, 5'h11, 16'h0800);
    apply("R5 shr-max", 16'hFFFF, 16'h000F, 5'h11, 16'h0001);
    apply("R5 shr-highbits-ignored", 16'h0100, 16'h0012, 5'h11, 16'h0040);
  endtask

  task automatic t_sra;
    apply("R6 sra-neg", 16'h8000, 16'h0004, 5'h13, 16'hF800);
    apply("R6 sra-pos", 16'h4000, 16'h0004, 5'h13, 16'h0400);
    apply("R6 sra-max", 16'h8001, 16'h000F, 5'h13, 16'hFFFF);
    apply("R6 sra-highbits-ignored", 16'h8000, 16'hA001, 5'h13, 16'hC000);
  endtask

  task automatic t_zero_shift;
    apply("R7 shl-zero", 16'hBEEF, 16'hFFF0, 5'h10, 16'hBEEF);
    apply("R7 shr-zero", 16'hBEEF, 16'h0000, 5'h11, 16'hBEEF);
    apply("R7 sra-zero", 16'hBEEF, 16'h0010, 5'h13, 16'hBEEF);
  endtask

  task automatic t_compare;
    apply("R8 eq-true",  16'h7FFF, 16'h7FFF, 5'h18, 16'h0001);
    apply("R8 eq-false", 16'h7FFF, 16'h7FFE, 5'h18, 16'h0000);
    apply("R9 lt-signed-true",  16'hFFFF, 16'h0001, 5'h19, 16'h0001);
    apply("R9 lt-signed-false", 16'h0001, 16'hFFFF, 5'h19, 16'h0000);
    apply("R9 lt-overflow-edge", 16'h8000, 16'h7FFF, 5'h19, 16'h0001);
    apply("R10 le-equal", 16'h8000, 16'h8000, 5'h1A, 16'h0001);
    apply("R10 le-greater", 16'h7FFF, 16'h8000, 5'h1A, 16'h0000);
    apply("R11 ult-true",  16'h0001, 16'hFFFF, 5'h1B, 16'h0001);
    apply("R11 ult-false", 16'hFFFF, 16'h0001, 5'h1B, 16'h0000);
    apply("R11 ult-equal", 16'h1234, 16'h1234, 5'h1B, 16'h0000);
  endtask

  task automatic t_unused;
    for (int c = 0; c < 32; c++) begin
      logic [4:0] fc;
      fc = 5'(c);
      if (!(fc inside {5'h00, 5'h01, 5'h08, 5'h09, 5'h0A, 5'h10, 5'h11, 5'h13,
                       5'h18, 5'h19, 5'h1A, 5'h1B}))
        apply("R12 unused-code", 16'hFFFF, 16'h5A5A, fc, 16'h0000);
    end
  endtask

  task automatic t_sweep;
    logic [4:0] codes [12];
    codes = '{5'h00, 5'h01, 5'h08, 5'h09, 5'h0A, 5'h10, 5'h11, 5'h13,
              5'h18, 5'h19, 5'h1A, 5'h1B};
    for (int i = 0; i < 400; i++) begin
      logic [15:0] x, z;
      x = 16'($urandom);
      z = (i % 4 == 0) ? x : 16'($urandom);
      for (int k = 0; k < 12; k++)
        apply("R13 sweep", x, z, codes[k], model(x, z, codes[k]));
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    a = '0; b = '0; f = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shl();
    t_shr();
    t_sra();
    t_zero_shift();
    t_compare();
    t_unused();
    t_sweep();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got=timeout expected=completion");
    finish_run();
  end

endmodule